// File: doc/BRIEF.md
# Command-Byte Serial Register Port

This block is a serial slave that lets an external host reach an on-chip register file. The host lowers chip select and shifts in a command byte. The top bit of that byte selects write or read, and the low seven bits give the register address. One to three data bytes follow, most significant byte first. The number of data bytes depends on the width of the addressed register. Values narrower than the bytes that carry them are right-justified. When the final byte of a register has moved, the port expects a new command byte, so several accesses can share one chip-select window.

On the chip side the port drives a single-cycle write strobe with address and data. For a read it drives a single-cycle read strobe and captures the returned word in that same cycle. The serial pins are oversampled in the system clock domain. Write bits are taken on falling serial clock edges and read bits change on rising edges. Chip select going high abandons the frame at any point and clears the bit position, and any incomplete register write is dropped.

Top module: `srp_port`

## Requirements
- R1: After chip select falls, the first byte is a command: bit 7 = 1 selects write, bit 7 = 0 selects read, bits 6..0 are the register address; after a read command `reg_rd` pulses for one cycle with `reg_addr` equal to that address.
- R2: Bits on `din` are taken at falling `sclk` edges, MSB first, bytes most significant first; a write produces exactly one single-cycle `reg_wr` pulse, after the final data byte, with `reg_addr` and `reg_wdata`.
- R3: Register width follows address bits 1..0 for addresses below NUM_REGS (default 48): 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 24; the frame carries ceil(width/8) data bytes (1, 2, 2, 3).
- R4: Data is right-justified: bits of the shifted-in bytes above the register width are dropped on writes (a 12-bit register keeps only the low nibble of its first byte), and read data is sent with zeros above the width.
- R5: Read data appears on `dout` after rising `sclk` edges, MSB first, beginning with the first rising edge after the command byte's eighth falling edge.
- R6: Once the last data byte has moved in either direction, the next byte in the same chip-select window is taken as a new command.
- R7: Chip select rising before a write's last data bit has been taken (including in the same sampled cycle as that last falling edge) produces no `reg_wr`; the next frame starts with a command byte.
- R8: After a non-final write data byte, falling `sclk` edges within GAP_CYCLES clock cycles are ignored.
- R9: An address at or above NUM_REGS has a one-byte frame; a write to it gives no `reg_wr`, and a read of it returns zero without a `reg_rd` pulse.
- R10: `dout_oe` is low whenever `cs_n` is high and high while it is low; after reset `dout_oe` is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host, idle high |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial read data to host |
| dout_oe | output | 1 | Drive enable for the dout pad; pad floats when low |
| reg_addr | output | 7 | Register file address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 24 | Right-justified write data |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 24 | Read data, returned in the strobe cycle |

## Verification
Two events can arrive in the same sampled cycle: the falling edge that completes a write, and chip select rising. Both pass through synchronizers of equal depth. The bench provokes the collision by changing `sclk` and `cs_n` in the same time step on the last bit, and it expects no write. A second test raises chip select a few clocks after the last falling edge and expects the write to land. The other overlap is a stray falling edge during the commit window after a write byte. The bench expects the register to get exactly the value from the intended bits.

// File: rtl/srp_pkg.sv
// Shared constants, phase type and width helpers for the serial register port.
// Assumes a 7-bit address in the command byte and registers of at most 3 bytes.
package srp_pkg;
    localparam int CMD_ADDR_W = 7;
    localparam int MAX_BYTES  = 3;
    localparam int DATA_W     = 8 * MAX_BYTES;
    localparam int BITS_W     = $clog2(DATA_W + 1);
    localparam int BYTES_W    = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {PH_CMD, PH_WDATA, PH_RDATA} phase_e;

    // Register width in bits from its address; zero marks an unmapped address.
    function automatic logic [BITS_W-1:0] reg_bits(input logic [CMD_ADDR_W-1:0] addr,
                                                   input int num_regs);
        if (int'(addr) >= num_regs) return '0;
        case (addr[1:0])
            2'd0:    return BITS_W'(8);
            2'd1:    return BITS_W'(12);
            2'd2:    return BITS_W'(16);
            default: return BITS_W'(DATA_W);
        endcase
    endfunction

    // Bytes on the wire for a width; an unmapped register still takes one byte.
    function automatic logic [BYTES_W-1:0] reg_bytes(input logic [BITS_W-1:0] bits);
        if (bits == '0) return BYTES_W'(1);
        return BYTES_W'((int'(bits) + 7) / 8);
    endfunction

    // Mask with the low 'bits' bits set.
    function automatic logic [DATA_W-1:0] width_mask(input logic [BITS_W-1:0] bits);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(bits));
        return m;
    endfunction
endpackage

// File: rtl/srp_sync_edge.sv
// Brings cs_n, sclk and din into the clk domain through equal-depth
// synchronizers and flags sclk edges. Assumes sclk half periods are several
// clk cycles long and SYNC_STAGES >= 2.
module srp_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_hi,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic din_s
);
    logic [SYNC_STAGES-1:0] cs_pipe, sclk_pipe, din_pipe;
    logic                   sclk_prev;

    // Shift the three pins through their synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            sclk_pipe <= '1;
            din_pipe  <= '0;
            sclk_prev <= 1'b1;
        end else begin
            cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
            din_pipe  <= {din_pipe[SYNC_STAGES-2:0], din};
            sclk_prev <= sclk_pipe[SYNC_STAGES-1];
        end
    end

    assign cs_hi     = cs_pipe[SYNC_STAGES-1];
    assign din_s     = din_pipe[SYNC_STAGES-1];
    assign sclk_fall = sclk_prev & ~sclk_pipe[SYNC_STAGES-1];
    assign sclk_rise = ~sclk_prev & sclk_pipe[SYNC_STAGES-1];

    // R2: a falling edge is never flagged in two cycles running
    assert_single_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> !sclk_fall) else $error("double falling edge");
endmodule

// File: rtl/srp_frame_ctrl.sv
// Frame sequencer: assembles bytes from sampled din, decodes the command,
// counts data bytes against the addressed width, strobes the register bus
// and enforces the post-byte commit window. Chip select high aborts.
module srp_frame_ctrl
    import srp_pkg::*;
#(
    parameter int NUM_REGS   = 48,
    parameter int GAP_CYCLES = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_hi,
    input  logic                  sclk_fall,
    input  logic                  din_s,
    output logic [CMD_ADDR_W-1:0] reg_addr,
    output logic                  reg_wr,
    output logic [DATA_W-1:0]     reg_wdata,
    output logic                  reg_rd,
    output logic                  rd_load,
    output logic                  rd_active,
    output logic [BITS_W-1:0]     rd_bits,
    output logic [BYTES_W-1:0]    rd_bytes
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    phase_e                phase;
    logic [2:0]            bit_cnt;
    logic [BYTES_W-1:0]    byte_idx;
    logic [BYTES_W-1:0]    nbytes;
    logic [BITS_W-1:0]     nbits;
    logic [CMD_ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]     shreg;
    logic [GAP_W-1:0]      guard;

    logic [DATA_W-1:0]     next_shift;
    logic [BITS_W-1:0]     cmd_bits;
    logic                  accept, byte_done, last_byte;

    // Combinational view of the incoming bit and the decoded command width.
    always_comb begin
        next_shift = {shreg[DATA_W-2:0], din_s};
        cmd_bits   = reg_bits(next_shift[CMD_ADDR_W-1:0], NUM_REGS);
        accept     = sclk_fall && (guard == '0) && !cs_hi;
        byte_done  = (bit_cnt == 3'd7);
        last_byte  = (byte_idx == nbytes - BYTES_W'(1));
    end

    // Frame state machine, bit and byte counting, bus strobes and commit window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            nbytes    <= BYTES_W'(1);
            nbits     <= '0;
            addr_q    <= '0;
            shreg     <= '0;
            guard     <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            rd_load   <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr  <= 1'b0;
            reg_rd  <= 1'b0;
            rd_load <= 1'b0;
            if (guard != '0) guard <= guard - GAP_W'(1);
            if (cs_hi) begin
                phase    <= PH_CMD;
                bit_cnt  <= '0;
                byte_idx <= '0;
                guard    <= '0;
            end else if (accept) begin
                shreg   <= next_shift;
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done) begin
                    case (phase)
                        PH_CMD: begin
                            addr_q   <= next_shift[CMD_ADDR_W-1:0];
                            nbits    <= cmd_bits;
                            nbytes   <= reg_bytes(cmd_bits);
                            byte_idx <= '0;
                            if (next_shift[7]) begin
                                phase <= PH_WDATA;
                            end else begin
                                phase   <= PH_RDATA;
                                rd_load <= 1'b1;
                                reg_rd  <= (cmd_bits != '0);
                            end
                        end
                        PH_WDATA: begin
                            if (last_byte) begin
                                phase <= PH_CMD;
                                if (nbits != '0) begin
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= next_shift & width_mask(nbits);
                                end
                            end else begin
                                byte_idx <= byte_idx + BYTES_W'(1);
                                guard    <= GAP_W'(GAP_CYCLES);
                            end
                        end
                        default: begin
                            if (last_byte) phase <= PH_CMD;
                            else           byte_idx <= byte_idx + BYTES_W'(1);
                        end
                    endcase
                end
            end
        end
    end

    assign reg_addr  = addr_q;
    assign rd_active = (phase == PH_RDATA);
    assign rd_bits   = nbits;
    assign rd_bytes  = nbytes;

    // R9: writes only reach mapped registers
    assert_wr_mapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (int'(reg_addr) < NUM_REGS)) else $error("write to unmapped address");
    // R2: one write strobe per frame, never back to back
    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr) else $error("write strobe longer than one cycle");
    // R4: write data never carries bits above the addressed width
    assert_wr_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ((reg_wdata & ~width_mask(reg_bits(reg_addr, NUM_REGS))) == '0))
        else $error("write data wider than register");
    // R7: chip select high returns to command phase with no write
    assert_abort_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (phase == PH_CMD && bit_cnt == 3'd0 && !reg_wr))
        else $error("abort did not reset frame");
    // R8: no write can complete inside the commit window
    assert_gap_no_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (guard != '0) |-> !reg_wr) else $error("write inside commit window");
endmodule

// File: rtl/srp_read_shift.sv
// Read serializer: loads the returned word, masked to the register width and
// left-aligned to the frame's byte count, and shifts it out MSB first on
// rising sclk edges while the frame is in its read phase.
module srp_read_shift
    import srp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_hi,
    input  logic               sclk_rise,
    input  logic               rd_active,
    input  logic               rd_load,
    input  logic [BITS_W-1:0]  rd_bits,
    input  logic [BYTES_W-1:0] rd_bytes,
    input  logic [DATA_W-1:0]  reg_rdata,
    output logic               dout
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] aligned;

    // Zero the bits above the width, then move the word to the top of the frame.
    always_comb begin
        aligned = (reg_rdata & width_mask(rd_bits)) << (8 * (MAX_BYTES - int'(rd_bytes)));
    end

    // Load on the read strobe, shift one bit per rising edge in the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            dout  <= 1'b0;
        end else if (cs_hi) begin
            shreg <= '0;
            dout  <= 1'b0;
        end else if (rd_load) begin
            shreg <= aligned;
        end else if (sclk_rise) begin
            if (rd_active) begin
                dout  <= shreg[DATA_W-1];
                shreg <= {shreg[DATA_W-2:0], 1'b0};
            end else begin
                dout <= 1'b0;
            end
        end
    end

    // R10: the serial output is quiet once chip select is seen high
    assert_idle_dout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !dout) else $error("dout active after deselect");
    // R5: a load is a single-cycle event
    assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> !rd_load) else $error("read load longer than one cycle");
endmodule

// File: rtl/srp_port.sv
// Top of the command-byte serial register port: synchronizer, frame
// sequencer and read serializer. The register file sits outside and must
// return reg_rdata combinationally in the cycle reg_rd is high.
module srp_port
    import srp_pkg::*;
#(
    parameter int NUM_REGS    = 48,
    parameter int GAP_CYCLES  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  din,
    output logic                  dout,
    output logic                  dout_oe,
    output logic [CMD_ADDR_W-1:0] reg_addr,
    output logic                  reg_wr,
    output logic [DATA_W-1:0]     reg_wdata,
    output logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_rdata
);
    logic               cs_hi, sclk_fall, sclk_rise, din_s;
    logic               rd_load, rd_active;
    logic [BITS_W-1:0]  rd_bits;
    logic [BYTES_W-1:0] rd_bytes;

    srp_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_hi(cs_hi), .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .din_s(din_s)
    );

    srp_frame_ctrl #(.NUM_REGS(NUM_REGS), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_fall(sclk_fall), .din_s(din_s),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .rd_load(rd_load), .rd_active(rd_active), .rd_bits(rd_bits), .rd_bytes(rd_bytes)
    );

    srp_read_shift u_rdsh (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_rise(sclk_rise),
        .rd_active(rd_active), .rd_load(rd_load), .rd_bits(rd_bits),
        .rd_bytes(rd_bytes), .reg_rdata(reg_rdata), .dout(dout)
    );

    // The pad enable follows the pin directly so the line floats at once.
    assign dout_oe = ~cs_n;

    // R1: a bus read strobe only ever accompanies a mapped address
    assert_rd_mapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (int'(reg_addr) < NUM_REGS)) else $error("read of unmapped address");
endmodule

// File: tb/srp_port_bench.sv
module srp_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int GAP        = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic        dout, dout_oe, reg_wr, reg_rd;
    logic [6:0]  reg_addr;
    logic [23:0] reg_wdata, reg_rdata;

    logic [23:0] regs [0:127];
    int          wr_count = 0, rd_count = 0;
    logic [6:0]  last_wr_addr = '0, last_rd_addr = '0;
    logic [23:0] last_wr_data = '0;
    int          n_checks = 0, n_fail = 0;

    srp_port #(.GAP_CYCLES(GAP)) u_srp_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = regs[reg_addr];

    // Register file model and strobe recorder.
    always @(posedge clk) begin
        if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_count       <= wr_count + 1;
            last_wr_addr   <= reg_addr;
            last_wr_data   <= reg_wdata;
        end
        if (reg_rd) begin
            rd_count     <= rd_count + 1;
            last_rd_addr <= reg_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
        sclk = 1'b1;
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            din = tx[i];
            wait_clk(HALF);
            rx[i] = dout;
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic sel;
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic desel;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(HALF + 6);
    endtask

    task automatic write_frame(input logic [6:0] addr, input logic [23:0] bytes_v, input int n);
        logic [7:0] rx;
        xfer_byte({1'b1, addr}, rx);
        for (int k = n - 1; k >= 0; k--) begin
            xfer_byte(bytes_v[8*k +: 8], rx);
            if (k != 0) wait_clk(GAP + 10);
        end
    endtask

    task automatic read_frame(input logic [6:0] addr, input int n, output logic [23:0] val);
        logic [7:0] rx;
        val = '0;
        xfer_byte({1'b0, addr}, rx);
        for (int k = n - 1; k >= 0; k--) begin
            xfer_byte(8'h00, rx);
            val[8*k +: 8] = rx;
        end
    endtask

    task automatic t_reset;
        check("R10", {31'd0, dout_oe}, 32'd0, "dout_oe after reset");
        check("R10", {31'd0, reg_wr | reg_rd}, 32'd0, "strobes after reset");
    endtask

    task automatic t_write_widths;
        int c;
        c = wr_count;
        sel();
        check("R10", {31'd0, dout_oe}, 32'd1, "dout_oe while selected");
        write_frame(7'd4, 24'h0000A5, 1);
        desel();
        check("R10", {31'd0, dout_oe}, 32'd0, "dout_oe after deselect");
        check("R2", wr_count - c, 32'd1, "8-bit write count");
        check("R1", {25'd0, last_wr_addr}, 32'd4, "8-bit write addr");
        check("R3", {8'd0, last_wr_data}, 32'hA5, "8-bit write data");
        sel(); write_frame(7'd5, 24'h00F34C, 2); desel();
        check("R4", {8'd0, last_wr_data}, 32'h34C, "12-bit write drops top nibble");
        sel(); write_frame(7'd6, 24'h00BEEF, 2); desel();
        check("R3", {8'd0, last_wr_data}, 32'hBEEF, "16-bit write data");
        sel(); write_frame(7'd7, 24'h123456, 3); desel();
        check("R3", {8'd0, last_wr_data}, 32'h123456, "24-bit write data");
        check("R2", wr_count - c, 32'd4, "one strobe per frame");
    endtask

    task automatic t_reads;
        logic [23:0] v;
        int c;
        regs[9]  = 24'h000ABC;
        regs[10] = 24'h008001;
        regs[11] = 24'hC0FFEE;
        regs[13] = 24'hFFFFFF;
        c = rd_count;
        sel(); read_frame(7'd9, 2, v); desel();
        check("R5", {8'd0, v}, 32'h0ABC, "12-bit read");
        check("R1", {25'd0, last_rd_addr}, 32'd9, "read strobe address");
        sel(); read_frame(7'd10, 2, v); desel();
        check("R5", {8'd0, v}, 32'h8001, "16-bit read");
        sel(); read_frame(7'd11, 3, v); desel();
        check("R5", {8'd0, v}, 32'hC0FFEE, "24-bit read");
        sel(); read_frame(7'd13, 2, v); desel();
        check("R4", {8'd0, v}, 32'h0FFF, "12-bit read zero above width");
        check("R1", rd_count - c, 32'd4, "read strobe count");
    endtask

    task automatic t_back_to_back;
        logic [23:0] v;
        sel();
        write_frame(7'd8, 24'h00003C, 1);
        read_frame(7'd8, 1, v);
        write_frame(7'd12, 24'h000077, 1);
        desel();
        check("R6", {8'd0, v}, 32'h3C, "read after write in one select");
        check("R6", {25'd0, last_wr_addr}, 32'd12, "third command decoded");
    endtask

    task automatic t_abort;
        int c;
        c = wr_count;
        sel();
        write_frame(7'd7, 24'h0000AA, 1);
        wait_clk(GAP + 10);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        desel();
        check("R7", wr_count - c, 32'd0, "mid-byte abort writes nothing");
        sel();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        desel();
        sel(); write_frame(7'd6, 24'h000102, 2); desel();
        check("R7", {8'd0, last_wr_data}, 32'h0102, "frame after aborted command");
        check("R7", wr_count - c, 32'd1, "only the clean frame wrote");
        // Collision: last falling edge and chip select rise in one time step.
        c = wr_count;
        sel();
        begin
            logic [7:0] rx;
            xfer_byte(8'h84, rx);
        end
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        din = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        cs_n = 1'b1;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF + 6);
        check("R7", wr_count - c, 32'd0, "chip select wins collision");
        // Chip select rising shortly after the last edge lets the write land.
        sel(); write_frame(7'd4, 24'h000011, 1); wait_clk(1); cs_n = 1'b1; wait_clk(HALF + 6);
        check("R7", {8'd0, last_wr_data}, 32'h11, "write lands before deselect");
    endtask

    task automatic t_gap;
        logic [7:0] rx;
        sel();
        xfer_byte(8'h86, rx);
        xfer_byte(8'h12, rx);
        wait_clk(2);
        din = 1'b1;
        sclk = 1'b0;
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(GAP + 10);
        xfer_byte(8'h34, rx);
        desel();
        check("R8", {8'd0, last_wr_data}, 32'h1234, "stray edge in commit window ignored");
    endtask

    task automatic t_unmapped;
        logic [23:0] v;
        int c, r;
        c = wr_count;
        r = rd_count;
        sel();
        write_frame(7'd60, 24'h0000FF, 1);
        write_frame(7'd4, 24'h00005A, 1);
        desel();
        check("R9", wr_count - c, 32'd1, "unmapped write ignored");
        check("R9", {8'd0, last_wr_data}, 32'h5A, "next command after one-byte frame");
        sel();
        read_frame(7'd100, 1, v);
        check("R9", {8'd0, v}, 32'h0, "unmapped read is zero");
        read_frame(7'd4, 1, v);
        desel();
        check("R9", {8'd0, v}, 32'h5A, "read after unmapped frame");
        check("R9", rd_count - r, 32'd1, "no strobe for unmapped read");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) regs[i] = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_write_widths();
        t_reads();
        t_back_to_back();
        t_abort();
        t_gap();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule